// File: doc/BRIEF.md
# Iterative Divider with Cycle Accounting

This unit divides a 32-bit dividend by a 16-bit divisor over several clock cycles. It works in unsigned or two's-complement signed mode. It returns a 16-bit quotient, a 16-bit remainder, an overflow flag and a divide-by-zero flag. Alongside the arithmetic it reports the number of bus clock cycles that a register-operand divide of those exact operands would cost on a classic microcoded processor. That count depends on the data. It comes from a shift-and-subtract schedule and includes the early-exit paths. A surrounding core uses the count to stall for the correct time. Memory-operand address timing and the trap taken on a zero divisor are left to that core.

Operation is a start/busy/done handshake. A `start` pulse while the unit is idle captures the operands and the mode. The controller then steps through these states:

- `ST_IDLE`: waits for a start.
- `ST_CHECK`: screens for a zero divisor and for an overflow that can be seen before any iteration. If either is found, the operation finishes at once and the controller returns to `ST_IDLE`. Otherwise it loads the iteration registers.
- `ST_ITER`: runs 16 restoring steps. In parallel it runs the 15-step unsigned timing schedule.
- `ST_FINISH`: applies the signs, checks for signed overflow, forms the cycle count, pulses `done` and goes back to `ST_IDLE`.

Top module: `iter_div_cyc`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `overflow` and `div_zero` are 0, and `quotient`, `remainder` and `cycles` are 0.
- R2: A `start` seen high at a clock edge while idle raises `busy` after that edge. `done` is a single-cycle pulse during which `busy` is 0. `done` rises one clock after the capturing edge on the zero-divisor and pre-iteration overflow exits, and 18 clocks after it otherwise.
- R3: `start` and operand changes while `busy` is 1 have no effect on the result of the operation in progress.
- R4: A divisor of 0 sets `div_zero`=1, `overflow`=0 and `cycles`=0, and leaves `quotient` and `remainder` unchanged.
- R5: When `signed_mode`=0 and dividend[31:16] >= divisor (nonzero), `overflow`=1 and `cycles`=6. `quotient` and `remainder` are unchanged.
- R6: When `signed_mode`=0 without overflow, `quotient`/`remainder` are the unsigned quotient and remainder. `cycles` = 2*h-4, where h starts at 38 and a 15-step schedule updates it. Each step shifts a 32-bit register (initially the dividend) left by one and compares it with divisor<<16. If the bit shifted out was 1, the step subtracts and adds 0 to h. Otherwise it adds 2 to h, and if the shifted value is >= divisor<<16 it subtracts and adds 1 to h instead. The result lies between 72 and 132.
- R7: When `signed_mode`=1, let |a| and |b| be the 32-bit and 16-bit unsigned magnitudes. If |a|[31:16] >= |b| (nonzero), `overflow`=1 and `cycles` is 12 for a non-negative dividend or 14 for a negative one. Results are unchanged.
- R8: When `signed_mode`=1 without overflow, the quotient magnitude is |a|/|b| and the remainder magnitude is |a| mod |b|. The quotient is negative when exactly one operand is negative. The remainder takes the sign of the dividend.
- R9: When `signed_mode`=1 past the pre-check, `cycles` = 2*h-4 with h = 61 + (dividend<0) + k + z. k is -1 if both operands are non-negative, +1 if the divisor is non-negative and the dividend negative, and 0 if the divisor is negative. z is the number of zero bits among bits 15..1 of |a|/|b|.
- R10: When `signed_mode`=1 and the signed quotient falls outside -32768..32767, `overflow`=1 and `cycles` still follows R9. `quotient` and `remainder` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a divide when idle |
| signed_mode | input | 1 | 1 = signed, 0 = unsigned |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 16 | Quotient (kept on overflow or zero divisor) |
| remainder | output | 16 | Remainder (kept on overflow or zero divisor) |
| overflow | output | 1 | Quotient did not fit |
| div_zero | output | 1 | Divisor was zero |
| cycles | output | 8 | Bus clock cycles the divide costs |

## Verification
The assertions assume that `start` is used only as a handshake. The count bounds they check depend on the mode being held in the unit's own capture register, not on the live `signed_mode` pin. The stimulus keeps to this: it raises `start` only at idle, except for deliberate pulses during `busy` that show they are ignored. It draws most random operands with the upper dividend half below the divisor so that the iteration path is reached, and mixes in unconstrained operands, zero divisors and extreme signed values such as -32768 and 0x80000000.

// File: rtl/div_cyc_pkg.sv
package div_cyc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ITER,
        ST_FINISH
    } dstate_t;

    // half-cycle accounting constants of the timing schedule
    localparam int U_OVF_HALF  = 5;
    localparam int U_BASE_HALF = 38;
    localparam int S_BASE_HALF = 6;
    localparam int S_ITER_HALF = 55;
    localparam int S_OVF_HALF  = 2;
    localparam int FETCH_ADJ   = 4;
endpackage

// File: rtl/div_step.sv
module div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] q_in,
    input  logic [W-1:0] dsr,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] q_out
);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       ge;

    always_comb begin
        trial   = {rem_in, q_in[W-1]};
        diff    = trial - {1'b0, dsr};
        ge      = trial >= {1'b0, dsr};
        rem_out = ge ? diff[W-1:0] : trial[W-1:0];
        q_out   = {q_in[W-2:0], ge};
    end
endmodule

// File: rtl/ucyc_step.sv
module ucyc_step #(
    parameter int W  = 16,
    parameter int HW = 8
) (
    input  logic [2*W-1:0] sh_in,
    input  logic [W-1:0]   dsr,
    input  logic [HW-1:0]  half_in,
    output logic [2*W-1:0] sh_out,
    output logic [HW-1:0]  half_out
);
    logic [2*W-1:0] hd;
    logic [2*W-1:0] shifted;

    always_comb begin
        hd       = {dsr, {W{1'b0}}};
        shifted  = {sh_in[2*W-2:0], 1'b0};
        sh_out   = shifted;
        half_out = half_in;
        if (sh_in[2*W-1]) begin
            sh_out = shifted - hd;
        end else if (shifted >= hd) begin
            sh_out   = shifted - hd;
            half_out = half_in + HW'(1);
        end else begin
            half_out = half_in + HW'(2);
        end
    end
endmodule

// File: rtl/iter_div_cyc.sv
module iter_div_cyc
    import div_cyc_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CYC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               signed_mode,
    input  logic [2*DIV_W-1:0] dividend,
    input  logic [DIV_W-1:0]   divisor,
    output logic               busy,
    output logic               done,
    output logic [DIV_W-1:0]   quotient,
    output logic [DIV_W-1:0]   remainder,
    output logic               overflow,
    output logic               div_zero,
    output logic [CYC_W-1:0]   cycles
);
    localparam int DVD_W = 2 * DIV_W;
    localparam int CW    = $clog2(DIV_W);
    localparam logic [CW-1:0] LAST_STEP = CW'(DIV_W - 1);

    dstate_t state, state_nx;

    logic [DVD_W-1:0] dvd_r, mag_dvd, sh_r, sh_nx;
    logic [DIV_W-1:0] dsr_r, mag_dsr, rem_r, q_r, rem_nx, q_nx;
    logic [DIV_W-1:0] fin_q, fin_r;
    logic [CYC_W-1:0] half_r, half_nx, zcnt, s_half, fin_half, fin_cyc, pre_cyc;
    logic [CW-1:0]    step_cnt;
    logic             mode_r, neg_dvd, neg_dsr, q_neg, is_zero, pre_ovf, s_ovf;

    assign neg_dvd = mode_r & dvd_r[DVD_W-1];
    assign neg_dsr = mode_r & dsr_r[DIV_W-1];
    assign mag_dvd = neg_dvd ? (~dvd_r + DVD_W'(1)) : dvd_r;
    assign mag_dsr = neg_dsr ? (~dsr_r + DIV_W'(1)) : dsr_r;
    assign is_zero = (dsr_r == '0);
    assign pre_ovf = (mag_dvd[DVD_W-1:DIV_W] >= mag_dsr);
    assign busy    = (state != ST_IDLE);

    div_step #(.W(DIV_W)) u_step (
        .rem_in (rem_r),
        .q_in   (q_r),
        .dsr    (mag_dsr),
        .rem_out(rem_nx),
        .q_out  (q_nx)
    );

    ucyc_step #(.W(DIV_W), .HW(CYC_W)) u_ucyc (
        .sh_in   (sh_r),
        .dsr     (mag_dsr),
        .half_in (half_r),
        .sh_out  (sh_nx),
        .half_out(half_nx)
    );

    // early-exit count and final result shaping
    always_comb begin
        zcnt = '0;
        for (int i = 1; i < DIV_W; i++) begin
            if (!q_r[i]) zcnt = zcnt + CYC_W'(1);
        end
        s_half = CYC_W'(S_BASE_HALF + S_ITER_HALF) + {{(CYC_W-1){1'b0}}, neg_dvd} + zcnt;
        if (!neg_dsr) begin
            s_half = neg_dvd ? (s_half + CYC_W'(1)) : (s_half - CYC_W'(1));
        end
        fin_half = mode_r ? s_half : half_r;
        fin_cyc  = {fin_half[CYC_W-2:0], 1'b0} - CYC_W'(FETCH_ADJ);
        pre_cyc  = mode_r
                 ? CYC_W'(2 * (S_BASE_HALF + S_OVF_HALF) - FETCH_ADJ) + {{(CYC_W-2){1'b0}}, neg_dvd, 1'b0}
                 : CYC_W'(2 * U_OVF_HALF - FETCH_ADJ);
        q_neg = neg_dvd ^ neg_dsr;
        s_ovf = mode_r & (q_neg ? (q_r > {1'b1, {(DIV_W-1){1'b0}}}) : q_r[DIV_W-1]);
        fin_q = q_neg ? (~q_r + DIV_W'(1)) : q_r;
        fin_r = neg_dvd ? (~rem_r + DIV_W'(1)) : rem_r;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_CHECK;
            ST_CHECK:  state_nx = (is_zero || pre_ovf) ? ST_IDLE : ST_ITER;
            ST_ITER:   if (step_cnt == LAST_STEP) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_r <= '0; dsr_r <= '0; mode_r <= 1'b0;
            rem_r <= '0; q_r <= '0; sh_r <= '0; half_r <= '0; step_cnt <= '0;
            quotient <= '0; remainder <= '0; overflow <= 1'b0; div_zero <= 1'b0;
            cycles <= '0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    dvd_r  <= dividend;
                    dsr_r  <= divisor;
                    mode_r <= signed_mode;
                end
                ST_CHECK: begin
                    if (is_zero) begin
                        div_zero <= 1'b1; overflow <= 1'b0; cycles <= '0; done <= 1'b1;
                    end else if (pre_ovf) begin
                        div_zero <= 1'b0; overflow <= 1'b1; cycles <= pre_cyc; done <= 1'b1;
                    end else begin
                        rem_r    <= mag_dvd[DVD_W-1:DIV_W];
                        q_r      <= mag_dvd[DIV_W-1:0];
                        sh_r     <= mag_dvd;
                        half_r   <= CYC_W'(U_BASE_HALF);
                        step_cnt <= '0;
                    end
                end
                ST_ITER: begin
                    rem_r    <= rem_nx;
                    q_r      <= q_nx;
                    step_cnt <= step_cnt + CW'(1);
                    if (step_cnt != LAST_STEP) begin
                        sh_r   <= sh_nx;
                        half_r <= half_nx;
                    end
                end
                ST_FINISH: begin
                    div_zero <= 1'b0;
                    overflow <= s_ovf;
                    cycles   <= fin_cyc;
                    done     <= 1'b1;
                    if (!s_ovf) begin
                        quotient  <= fin_q;
                        remainder <= fin_r;
                    end
                end
                default: ;
            endcase
        end
    end

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R3
    ops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(dvd_r) && $stable(dsr_r) && $stable(mode_r)));
    // R4
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (cycles == '0 && !overflow));
    // R10
    result_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (overflow || div_zero)) |-> ($stable(quotient) && $stable(remainder)));
    // R6
    ucyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !overflow && !div_zero && !mode_r) |->
        (cycles >= CYC_W'(72) && cycles <= CYC_W'(132) && !cycles[0]));
    // R9
    scyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_zero && mode_r && state == ST_IDLE && $past(state) == ST_FINISH) |->
        (cycles >= CYC_W'(116) && cycles <= CYC_W'(152)));
endmodule

// File: tb/iter_div_cyc_tb.sv
module iter_div_cyc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        signed_mode = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, overflow, div_zero;
    logic [15:0] quotient, remainder;
    logic [7:0]  cycles;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_q = '0;
    logic [15:0] exp_r = '0;

    always #2.5 clk = ~clk;

    iter_div_cyc u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder), .overflow(overflow),
        .div_zero(div_zero), .cycles(cycles)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // reference model, computed from the requirements
    task automatic ref_model(input logic [31:0] a, input logic [15:0] b, input logic sgn,
                             output logic e_ovf, output logic e_dz, output logic [7:0] e_cyc,
                             output logic early);
        logic [31:0] ma, aq, ar, sh, hd;
        logic [15:0] mb;
        logic        na, nb, qn;
        int          h;
        na = sgn & a[31];
        nb = sgn & b[15];
        ma = na ? -a : a;
        mb = nb ? -b : b;
        e_ovf = 1'b0; e_dz = 1'b0; early = 1'b0; e_cyc = 8'd0;
        if (b == 16'd0) begin
            e_dz = 1'b1; early = 1'b1;
        end else if (ma[31:16] >= mb) begin
            e_ovf = 1'b1; early = 1'b1;
            e_cyc = sgn ? (na ? 8'd14 : 8'd12) : 8'd6;
        end else begin
            aq = ma / {16'd0, mb};
            ar = ma % {16'd0, mb};
            if (!sgn) begin
                h = 38; sh = a; hd = {b, 16'd0};
                for (int i = 0; i < 15; i++) begin
                    if (sh[31]) sh = (sh << 1) - hd;
                    else begin
                        sh = sh << 1; h += 2;
                        if (sh >= hd) begin sh = sh - hd; h -= 1; end
                    end
                end
                exp_q = aq[15:0]; exp_r = ar[15:0];
            end else begin
                h = 61 + (na ? 1 : 0);
                if (!nb) h += na ? 1 : -1;
                for (int i = 1; i < 16; i++) if (!aq[i]) h++;
                qn = na ^ nb;
                if (qn ? (aq > 32'd32768) : (aq > 32'd32767)) e_ovf = 1'b1;
                else begin
                    exp_q = qn ? -aq[15:0] : aq[15:0];
                    exp_r = na ? -ar[15:0] : ar[15:0];
                end
            end
            e_cyc = 8'(2 * h - 4);
        end
    endtask

    task automatic run_op(input string tag, input logic [31:0] a, input logic [15:0] b,
                          input logic sgn, input logic inject);
        logic e_ovf, e_dz, early;
        logic [7:0] e_cyc;
        int lat;
        ref_model(a, b, sgn, e_ovf, e_dz, e_cyc, early);
        @(negedge clk);
        dividend = a; divisor = b; signed_mode = sgn; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check({tag, " R2 busy"}, {31'd0, busy}, 32'd1);
        lat = 0;
        while (!done && lat < 40) begin
            if (inject && lat == 3) begin
                // R3: new operands and a start during busy
                dividend = ~a; divisor = b ^ 16'h00F3; signed_mode = ~sgn; start = 1'b1;
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        check({tag, " R2 latency"}, lat, early ? 32'd1 : 32'd18);
        check({tag, " R2 busy@done"}, {31'd0, busy}, 32'd0);
        check({tag, " R4 div_zero"}, {31'd0, div_zero}, {31'd0, e_dz});
        check({tag, " R10 overflow"}, {31'd0, overflow}, {31'd0, e_ovf});
        check({tag, sgn ? " R9 cycles" : " R6 cycles"}, {24'd0, cycles}, {24'd0, e_cyc});
        check({tag, sgn ? " R8 quotient" : " R6 quotient"}, {16'd0, quotient}, {16'd0, exp_q});
        check({tag, sgn ? " R8 remainder" : " R6 remainder"}, {16'd0, remainder}, {16'd0, exp_r});
        @(negedge clk);
        check({tag, " R2 done pulse"}, {31'd0, done}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] a;
        logic [15:0] b;
        void'($urandom(32'h5EED_0007));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 outputs", {quotient, remainder}, 32'd0);
        check("R1 flags", {22'd0, overflow, div_zero, cycles}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {29'd0, busy, done, overflow}, 32'd0);

        // directed unsigned
        run_op("u_basic", 32'd100, 16'd7, 1'b0, 1'b0);
        run_op("u_zero R4", 32'd1234, 16'd0, 1'b0, 1'b0);
        run_op("u_ovf R5", 32'h0005_0000, 16'd5, 1'b0, 1'b0);
        run_op("u_worst R6", 32'd0, 16'd1, 1'b0, 1'b0);
        run_op("u_big R6", 32'hFFFE_FFFF, 16'hFFFF, 1'b0, 1'b0);
        // directed signed
        run_op("s_negdvd R8", -32'sd7, 16'd2, 1'b1, 1'b0);
        run_op("s_negdsr R8", 32'd7, -16'sd2, 1'b1, 1'b0);
        run_op("s_both R8", -32'sd100, -16'sd9, 1'b1, 1'b0);
        run_op("s_absovf R7", 32'h8000_0000, 16'h8000, 1'b1, 1'b0);
        run_op("s_absovf_pos R7", 32'h0003_0000, 16'd2, 1'b1, 1'b0);
        run_op("s_late_ovf R10", 32'h0000_8000, 16'd1, 1'b1, 1'b0);
        run_op("s_minq R8", 32'hFFFF_8000, 16'd1, 1'b1, 1'b0);
        run_op("s_late_neg R10", 32'hFFFF_7FFF, 16'd1, 1'b1, 1'b0);
        run_op("s_zero R4", -32'sd5, 16'd0, 1'b1, 1'b0);
        // R3 ignored start while busy
        run_op("u_inject R3", 32'h0012_3456, 16'h0345, 1'b0, 1'b1);
        run_op("s_inject R3", -32'sd98765, 16'd321, 1'b1, 1'b1);

        // constrained random
        for (int k = 0; k < 300; k++) begin
            b = 16'($urandom);
            a = $urandom;
            if (k % 4 != 0 && b != 0) begin
                if (k % 2 == 0) a[31:16] = 16'($urandom % {16'd0, b});
                else a = $signed(a) >>> ($urandom % 20 + 12);
            end
            if (k % 37 == 0) b = 16'd0;
            run_op((k % 2 == 0) ? "rnd_u R6" : "rnd_s R9", a, b, k[0], k % 23 == 5);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule